// File: doc/BRIEF.md
# Prioritized Interrupt Control Unit

This block gathers up to 64 interrupt request inputs and raises a single interrupt line toward a processor. Each source has its own control word that selects how the input is sensed (falling edge, low level, rising edge or high level), gives it a 3-bit priority, and holds an enable bit and a pending bit. Inputs pass through a two-flop synchronizer before any detection.

A global mask level decides which priorities are admitted. Among the admitted sources that are pending and enabled, the most urgent one wins. A status word reports the winner's source number and priority, and carries a fixed vector-base field chosen at build time. Software reaches the per-source control words, the mask and the status word through a simple 32-bit register bus with single-cycle writes and combinational reads.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the CPU interrupt output is low, the mask reads 0, every source control word reads 0x07 (priority 7, sense 00, pending 0, enable 0), and the status word reads vector base, source 0, level 7.
- R2: A source control word has priority in bits [2:0], sense mode in bits [4:3], pending in bit 5 and enable in bit 6; bits [31:7] read as 0. Priority, sense mode and enable read back as written.
- R3: In sense mode 00 (falling edge) a high-to-low input transition sets the pending bit, visible on the third rising clock edge after the input change; the bit stays set after the input returns high.
- R4: In sense mode 10 (rising edge) a low-to-high transition sets the pending bit with the same latency, and a high-to-low transition has no effect.
- R5: In sense modes 01 (low level) and 11 (high level) the pending bit shows the synchronized input level (active low or active high); writes to the pending bit have no effect.
- R6: In an edge mode, writing a control word with bit 5 = 0 clears the pending bit and writing bit 5 = 1 leaves it unchanged; a detected edge in the same cycle as a clearing write leaves the bit set.
- R7: The CPU interrupt output is high exactly when some source is pending, enabled, has priority other than 7 and has priority numerically below the mask value; mask 0 blocks every source.
- R8: Among qualifying sources the one with the smallest priority value wins; equal priorities go to the lowest source number.
- R9: The status word holds the vector base in bits [31:28], the winner's source number in bits [13:8] and its priority in bits [2:0], all other bits 0; with no winner it reports source 0 and level 7.
- R10: Word address 0x00 is the read-only status word, 0x01 holds the mask in bits [2:0], and 0x40+i holds source i's control word; addresses for sources beyond the configured count read 0 and writes to the status word have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NSRC | Raw request inputs, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The assertions check on every cycle that the interrupt line agrees with the set of qualifying sources, that nothing qualifies under mask 0, that the winner is itself a qualifying source admitted by the mask, and that the status word carries the vector base and the winner's fields. Which source should win, the latency and persistence of edge capture, the effect of clearing writes and the ignored writes in level mode can only be shown by the bench's scenarios, including a sweep of every input pattern against every mask value under several priority and enable configurations.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int          PRIO_W   = 3;
  localparam logic [2:0]  PRIO_OFF = 3'd7;
  localparam int          ID_OUT_W = 6;

  typedef enum logic [1:0] {
    SENSE_FALL = 2'b00,
    SENSE_LOW  = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_HIGH = 2'b11
  } sense_e;

  // bit 6 enable, bit 5 pending, bits 4:3 sense, bits 2:0 priority
  typedef struct packed {
    logic        en;
    logic        pend;
    sense_e      sense;
    logic [2:0]  prio;
  } src_ctrl_t;

  localparam logic [7:0] ADDR_STATUS = 8'h00;
  localparam logic [7:0] ADDR_MASK   = 8'h01;
  localparam logic [1:0] SRC_REGION  = 2'b01;

  function automatic logic admitted(input logic [2:0] prio, input logic [2:0] mask);
    return (prio != PRIO_OFF) && (prio < mask);
  endfunction

  function automatic logic outranks(input logic [2:0] pa, input logic [5:0] ia,
                                    input logic [2:0] pb, input logic [5:0] ib);
    return (pa < pb) || ((pa == pb) && (ia < ib));
  endfunction

  function automatic logic [31:0] pack_status(input logic [3:0] vec, input logic [5:0] id,
                                              input logic [2:0] lvl);
    return {vec, 14'b0, id, 5'b0, lvl};
  endfunction
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/icu_source.sv
module icu_source
  import icu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_in,
  input  logic       wr_ctrl,
  input  src_ctrl_t  wr_val,
  input  logic [2:0] mask_lvl,
  output src_ctrl_t  ctrl_view,
  output logic       eligible
);
  logic   s_now, s_prev;
  logic   en_q, latch_q;
  sense_e sense_q;
  logic [2:0] prio_q;
  logic   level_mode, level_val, edge_hit, pend_eff;

  icu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(s_now)
  );

  assign level_mode = sense_q[0];
  assign level_val  = sense_q[1] ? s_now : ~s_now;
  assign edge_hit   = ((sense_q == SENSE_FALL) && !s_now &&  s_prev) ||
                      ((sense_q == SENSE_RISE) &&  s_now && !s_prev);
  assign pend_eff   = level_mode ? level_val : latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_prev  <= 1'b0;
      en_q    <= 1'b0;
      sense_q <= SENSE_FALL;
      prio_q  <= PRIO_OFF;
      latch_q <= 1'b0;
    end else begin
      s_prev <= s_now;
      if (wr_ctrl) begin
        en_q    <= wr_val.en;
        sense_q <= wr_val.sense;
        prio_q  <= wr_val.prio;
      end
      if (level_mode)                  latch_q <= 1'b0;
      else if (edge_hit)               latch_q <= 1'b1;
      else if (wr_ctrl && !wr_val.pend) latch_q <= 1'b0;
    end
  end

  assign ctrl_view = '{en: en_q, pend: pend_eff, sense: sense_q, prio: prio_q};
  assign eligible  = en_q && pend_eff && admitted(prio_q, mask_lvl);
endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter
  import icu_pkg::*;
#(
  parameter int NSRC = 64,
  localparam int ID_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]        elig,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic                   win_valid,
  output logic [ID_W-1:0]        win_id,
  output logic [2:0]             win_prio
);
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_prio  = PRIO_OFF;
    for (int k = 0; k < NSRC; k++) begin
      if (elig[k] && (!win_valid ||
          outranks(prio_flat[k*PRIO_W +: PRIO_W], 6'(k), win_prio, 6'(win_id)))) begin
        win_valid = 1'b1;
        win_id    = ID_W'(k);
        win_prio  = prio_flat[k*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import icu_pkg::*;
#(
  parameter int         NSRC        = 64,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] VEC_BASE    = 4'h0,
  localparam int        ID_W        = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_src,
  input  logic            reg_we,
  input  logic [7:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            cpu_irq
);
  logic [2:0]              mask_lvl;
  logic [NSRC-1:0]         elig_vec;
  logic [NSRC*PRIO_W-1:0]  prio_flat;
  src_ctrl_t               views [NSRC];
  logic                    win_valid;
  logic [ID_W-1:0]         win_id;
  logic [2:0]              win_prio;
  logic                    src_sel;
  logic [5:0]              src_idx;
  logic [31:0]             status_word;

  assign src_sel = (reg_addr[7:6] == SRC_REGION);
  assign src_idx = reg_addr[5:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               mask_lvl <= 3'd0;
    else if (reg_we && reg_addr == ADDR_MASK) mask_lvl <= reg_wdata[2:0];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    icu_source #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (irq_src[i]),
      .wr_ctrl  (reg_we && src_sel && (src_idx == 6'(i))),
      .wr_val   (src_ctrl_t'(reg_wdata[6:0])),
      .mask_lvl (mask_lvl),
      .ctrl_view(views[i]),
      .eligible (elig_vec[i])
    );
    assign prio_flat[i*PRIO_W +: PRIO_W] = views[i].prio;
  end

  icu_arbiter #(.NSRC(NSRC)) u_arb (
    .elig     (elig_vec),
    .prio_flat(prio_flat),
    .win_valid(win_valid),
    .win_id   (win_id),
    .win_prio (win_prio)
  );

  assign cpu_irq     = win_valid;
  assign status_word = pack_status(VEC_BASE, 6'(win_id), win_prio);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_STATUS)    reg_rdata = status_word;
    else if (reg_addr == ADDR_MASK) reg_rdata = {29'b0, mask_lvl};
    else if (src_sel) begin
      for (int k = 0; k < NSRC; k++)
        if (src_idx == 6'(k)) reg_rdata = {25'b0, views[k]};
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int         NSRC     = 64,
  parameter logic [3:0] VEC_BASE = 4'h0,
  localparam int        ID_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_irq,
  input logic [7:0]      reg_addr,
  input logic [31:0]     reg_rdata,
  input logic [NSRC-1:0] elig_vec,
  input logic            win_valid,
  input logic [ID_W-1:0] win_id,
  input logic [2:0]      win_prio,
  input logic [2:0]      mask_lvl
);
  p_irq_follows_sources_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == (|elig_vec));

  p_mask_zero_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_lvl == 3'd0) |-> (!cpu_irq && elig_vec == '0));

  p_winner_qualifies_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (elig_vec[win_id] && win_prio < mask_lvl && win_prio != 3'd7));

  p_idle_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> (win_id == '0 && win_prio == 3'd7));

  p_status_fields_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h00) |-> (reg_rdata[31:28] == VEC_BASE &&
                             reg_rdata[13:8] == 6'(win_id) &&
                             reg_rdata[2:0] == win_prio &&
                             reg_rdata[27:14] == '0 && reg_rdata[7:3] == '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC), .VEC_BASE(VEC_BASE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_irq  (cpu_irq),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .elig_vec (elig_vec),
  .win_valid(win_valid),
  .win_id   (win_id),
  .win_prio (win_prio),
  .mask_lvl (mask_lvl)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int         N   = 8;
  localparam logic [3:0] VEC = 4'hA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_src = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cpu_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl #(.NSRC(N), .SYNC_STAGES(2), .VEC_BASE(VEC)) dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] model_status(input logic [N-1:0] pend, input logic [N-1:0] en,
                                               input logic [3*N-1:0] pr, input logic [2:0] mask);
    int best = -1;
    int bp = 7;
    for (int i = 0; i < N; i++) begin
      int p = int'(pr[i*3 +: 3]);
      if (en[i] && pend[i] && p != 7 && p < int'(mask) && (best < 0 || p < bp)) begin
        best = i; bp = p;
      end
    end
    if (best < 0) return {VEC, 28'h0000007};
    return {VEC, 14'b0, 6'(best), 5'b0, 3'(bp)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, cpu_irq}, 32'd0);
    rd(8'h00, v); chk("R1 status", v, {VEC, 28'h0000007});
    rd(8'h01, v); chk("R1 mask", v, 32'd0);
    for (int i = 0; i < N; i++) begin
      rd(8'h40 + 8'(i), v); chk("R1 ctrl", v, 32'h07);
    end

    // R2 layout and readback (inputs low, rising mode: nothing pends)
    for (int i = 0; i < N; i++) begin
      logic [31:0] val;
      val = (32'(i & 1) << 6) | (32'd2 << 3) | 32'(i % 7);
      wr(8'h40 + 8'(i), 32'hFFFF_FF80 | val);
      rd(8'h40 + 8'(i), v); chk("R2 readback", v, val);
    end

    // R7 R8 R9 sweep, high-level sense so pending equals input
    for (int cfg = 0; cfg < 3; cfg++) begin
      logic [3*N-1:0] pr;
      logic [N-1:0]   en;
      en = (cfg == 2) ? 8'b1010_1111 : 8'hFF;
      for (int i = 0; i < N; i++) begin
        logic [2:0] p;
        p = (cfg == 0) ? 3'(i) : (cfg == 1) ? 3'd3 : 3'(7 - i);
        pr[i*3 +: 3] = p;
        wr(8'h40 + 8'(i), {25'b0, en[i], 1'b0, 2'b11, p});
      end
      for (int m = 0; m < 8; m++) begin
        wr(8'h01, 32'(m));
        for (int pat = 0; pat < 256; pat++) begin
          logic [31:0] e;
          irq_src = 8'(pat);
          settle();
          e = model_status(8'(pat), en, pr, 3'(m));
          rd(8'h00, v); chk("R8/R9 status", v, e);
          chk("R7 irq", {31'b0, cpu_irq}, {31'b0, (e[2:0] != 3'd7)});
        end
      end
    end

    // back to defaults, inputs high, falling mode
    irq_src = '1;
    for (int i = 0; i < N; i++) wr(8'h40 + 8'(i), 32'h07);
    wr(8'h01, 32'd7);
    settle();
    chk("R7 idle irq", {31'b0, cpu_irq}, 32'd0);

    // R3 falling edge on source 1, priority 2
    wr(8'h41, 32'h42);
    rd(8'h41, v); chk("R3 no pend yet", v, 32'h42);
    irq_src[1] = 1'b0;
    repeat (2) @(negedge clk);
    rd(8'h41, v); chk("R3 latency two edges", v, 32'h42);
    @(negedge clk);
    rd(8'h41, v); chk("R3 pend on third edge", v, 32'h62);
    chk("R3 irq", {31'b0, cpu_irq}, 32'd1);
    rd(8'h00, v); chk("R9 status src1", v, {VEC, 28'h0000102});
    irq_src[1] = 1'b1;
    settle();
    rd(8'h41, v); chk("R3 held", v, 32'h62);

    // R6 clearing writes
    wr(8'h41, 32'h62);
    rd(8'h41, v); chk("R6 write one keeps", v, 32'h62);
    wr(8'h41, 32'h42);
    rd(8'h41, v); chk("R6 write zero clears", v, 32'h42);
    chk("R6 irq dropped", {31'b0, cpu_irq}, 32'd0);
    irq_src[1] = 1'b0;
    repeat (2) @(negedge clk);
    wr(8'h41, 32'h42);
    rd(8'h41, v); chk("R6 edge beats clear", v, 32'h62);
    wr(8'h41, 32'h42);
    irq_src[1] = 1'b1;
    settle();
    rd(8'h41, v); chk("R6 cleared again", v, 32'h42);

    // R4 rising edge on source 2, priority 1
    wr(8'h42, 32'h51);
    irq_src[2] = 1'b0;
    settle();
    rd(8'h42, v); chk("R4 falling ignored", v, 32'h51);
    irq_src[2] = 1'b1;
    settle();
    rd(8'h42, v); chk("R4 rise pends", v, 32'h71);
    rd(8'h00, v); chk("R4 status src2", v, {VEC, 28'h0000201});
    wr(8'h42, 32'h51);

    // R5 low-level on source 0, priority 0
    wr(8'h40, 32'h48);
    rd(8'h40, v); chk("R5 high input idle", v, 32'h48);
    irq_src[0] = 1'b0;
    settle();
    rd(8'h40, v); chk("R5 low pends", v, 32'h68);
    rd(8'h00, v); chk("R5 status src0", v, {VEC, 28'h0000000});
    wr(8'h40, 32'h48);
    rd(8'h40, v); chk("R5 clear ignored", v, 32'h68);
    wr(8'h01, 32'd0);
    chk("R7 mask zero", {31'b0, cpu_irq}, 32'd0);
    wr(8'h01, 32'd1);
    chk("R7 mask one admits 0", {31'b0, cpu_irq}, 32'd1);
    irq_src[0] = 1'b1;
    settle();
    rd(8'h40, v); chk("R5 level released", v, 32'h48);

    // R10 address map
    wr(8'h01, 32'hFFFF_FFFD);
    rd(8'h01, v); chk("R10 mask field", v, 32'd5);
    rd(8'h00, v);
    wr(8'h00, 32'hFFFF_FFFF);
    begin
      logic [31:0] v2;
      rd(8'h00, v2); chk("R10 status write ignored", v2, v);
    end
    rd(8'h40 + 8'(N), v); chk("R10 absent source", v, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule